// File: doc/BRIEF.md
# Clock Enable and Memory Wait-State Controller

This block holds the timing configuration of a small processor core and applies it. Everything runs from the on-chip oscillator clock. A CPU clock enable runs either every oscillator cycle or every second one. A transceiver clock enable comes from one of three oscillator divisions or from an external clock input. A one-in-eight bit-sample strobe is derived from the transceiver enable. A clock output repeats the oscillator unchanged. One cycle of the oscillator in which the CPU enable is high is a CPU state.

Memory accesses use a valid/ready handshake. The CPU raises `req_valid_i` with `req_is_data_i` set for a data-memory access and clear for an instruction fetch. It must hold both steady until it sees `req_ready_o` high at a rising edge. That edge completes the access. The block inserts the programmed number of wait states by holding ready low for that many CPU states. Ready is only ever high in a CPU state and only while valid is high. Each access latches its wait count when it starts, so a configuration write during an access changes only later accesses.

The configuration register is written a whole byte at a time. Its fields are: bits [1:0] transceiver select, bit [2] CPU half-rate, bits [4:3] instruction wait states, and bits [7:5] data wait states.

Top module: `timing_ctrl`

## Requirements
- R1: `clk_out_o` always equals the oscillator clock, whatever the configuration.
- R2: With config bit 2 clear, `cpu_ce_o` is high every cycle. With it set, `cpu_ce_o` is high on alternate cycles only: 10 of every 20 cycles, never two in a row.
- R3: Transceiver select (bits [1:0]) 00, 01 and 10 give `trx_ce_o` on every cycle, every 2nd cycle and every 4th cycle of the oscillator.
- R4: Select 11 gives exactly one `trx_ce_o` pulse for each rising edge of `xclk_i`.
- R5: `bit_stb_o` pulses once per eight `trx_ce_o` pulses, and only in a cycle where `trx_ce_o` is high.
- R6: An instruction access (`req_is_data_i`=0) sees `req_ready_o` low for exactly N CPU states, with N taken from bits [4:3] (0–3), and high in the following CPU state.
- R7: A data access (`req_is_data_i`=1) sees N wait states, with N taken from bits [7:5] (0–7).
- R8: After reset the instruction wait count is 3, the data wait count is 7, half-rate is off and the select is 00.
- R9: With zero wait states, ready rises in the first CPU state of the request. Ready is never high outside a CPU state or without valid.
- R10: A configuration write made during an access leaves that access's wait count unchanged. The next access uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | On-chip oscillator clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xclk_i | input | 1 | External transceiver clock, sampled by a synchronizer |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| req_valid_i | input | 1 | Memory access request, held until ready |
| req_is_data_i | input | 1 | 1 = data memory, 0 = instruction memory |
| req_ready_o | output | 1 | Access completes at the edge where this is high |
| cpu_ce_o | output | 1 | CPU clock enable (one CPU state per high cycle) |
| trx_ce_o | output | 1 | Transceiver clock enable |
| bit_stb_o | output | 1 | Bit-sample strobe, one per eight transceiver enables |
| clk_out_o | output | 1 | Undivided oscillator clock |

## Verification
A vector table sweeps access type, wait field values from 0 to the maximum, and both CPU rates. This separates a swapped field from an off-by-one count, and separates counting oscillator cycles from counting CPU states. Directed tests cover the reset wait counts and the count of enables under each transceiver select. They also drive the external clock with a known number of edges and count bit strobes. A final test writes a new wait value partway through an access, which shows whether the count was latched or read live.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int IW_W   = 2;
  localparam int DW_W   = 3;
  localparam int CFG_W  = 3 + IW_W + DW_W;
  localparam int BIT_DIV = 8;

  typedef enum logic [1:0] {
    TRX_DIV1 = 2'b00,
    TRX_DIV2 = 2'b01,
    TRX_DIV4 = 2'b10,
    TRX_EXT  = 2'b11
  } trx_sel_e;

  typedef struct packed {
    logic [DW_W-1:0] dw;
    logic [IW_W-1:0] iw;
    logic            cpu_half;
    trx_sel_e        sel;
  } cfg_t;
endpackage

// File: rtl/tc_cpu_ce.sv
module tc_cpu_ce (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  output logic ce_o
);
  logic ph_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign ce_o = !half_i || ph_q;
endmodule

// File: rtl/tc_trx_ce.sv
module tc_trx_ce
  import tc_pkg::*;
#(
  parameter int SYNC_N  = 2,
  parameter int STB_DIV = BIT_DIV
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  trx_sel_e sel_i,
  input  logic     xclk_i,
  output logic     trx_ce_o,
  output logic     bit_stb_o
);
  localparam int BC_W = (STB_DIV > 1) ? $clog2(STB_DIV) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(STB_DIV - 1);

  logic [1:0]        div_q;
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              ext_edge;
  logic [BC_W-1:0]   bit_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      div_q  <= div_q + 2'd1;
      sync_q <= {sync_q[SYNC_N-2:0], xclk_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign ext_edge = sync_q[SYNC_N-1] && !prev_q;

  always_comb begin
    unique case (sel_i)
      TRX_DIV1: trx_ce_o = 1'b1;
      TRX_DIV2: trx_ce_o = div_q[0];
      TRX_DIV4: trx_ce_o = (div_q == 2'd3);
      default:  trx_ce_o = ext_edge;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       bit_q <= '0;
    else if (trx_ce_o) bit_q <= (bit_q == BC_LAST) ? '0 : bit_q + BC_W'(1);
  end

  assign bit_stb_o = trx_ce_o && (bit_q == BC_LAST);
endmodule

// File: rtl/tc_wait.sv
module tc_wait #(
  parameter int IW_W = 2,
  parameter int DW_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_i,
  input  logic            valid_i,
  input  logic            is_data_i,
  input  logic [IW_W-1:0] iw_i,
  input  logic [DW_W-1:0] dw_i,
  output logic            ready_o
);
  localparam int CW = (DW_W > IW_W) ? DW_W : IW_W;

  logic          busy_q;
  logic [CW-1:0] rem_q;
  logic [CW-1:0] target;

  assign target  = is_data_i ? CW'(dw_i) : CW'(iw_i);
  assign ready_o = valid_i && ce_i && (busy_q ? (rem_q == '0) : (target == '0));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (ce_i && valid_i) begin
      if (!busy_q) begin
        if (target != '0) begin
          busy_q <= 1'b1;
          rem_q  <= target - CW'(1);
        end
      end else if (rem_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        rem_q <= rem_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/timing_ctrl.sv
module timing_ctrl
  import tc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xclk_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             req_valid_i,
  input  logic             req_is_data_i,
  output logic             req_ready_o,
  output logic             cpu_ce_o,
  output logic             trx_ce_o,
  output logic             bit_stb_o,
  output logic             clk_out_o
);
  localparam cfg_t CFG_RST = '{dw: '1, iw: '1, cpu_half: 1'b0, sel: TRX_DIV1};

  cfg_t cfg_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  assign clk_out_o = clk_i;

  tc_cpu_ce u_cpu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (cfg_q.cpu_half),
    .ce_o   (cpu_ce_o)
  );

  tc_trx_ce #(.SYNC_N(2), .STB_DIV(BIT_DIV)) u_trx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (cfg_q.sel),
    .xclk_i    (xclk_i),
    .trx_ce_o  (trx_ce_o),
    .bit_stb_o (bit_stb_o)
  );

  tc_wait #(.IW_W(IW_W), .DW_W(DW_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (cpu_ce_o),
    .valid_i   (req_valid_i),
    .is_data_i (req_is_data_i),
    .iw_i      (cfg_q.iw),
    .dw_i      (cfg_q.dw),
    .ready_o   (req_ready_o)
  );
endmodule

// File: rtl/tc_chk.sv
module tc_chk
  import tc_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_we_i,
  input cfg_t cfg_q,
  input logic req_valid_i,
  input logic req_is_data_i,
  input logic req_ready_o,
  input logic cpu_ce_o,
  input logic trx_ce_o,
  input logic bit_stb_o
);
  // R2
  full_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.cpu_half |-> cpu_ce_o);

  // R2
  half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.cpu_half && cpu_ce_o && !cfg_we_i) |=> !cpu_ce_o);

  // R3
  div4_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.sel == TRX_DIV4 && trx_ce_o && !cfg_we_i) |=> !trx_ce_o);

  // R5
  stb_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> trx_ce_o);

  // R9
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (req_valid_i && cpu_ce_o));

  // R6
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> (req_valid_i && $stable(req_is_data_i)));
endmodule

bind timing_ctrl tc_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_q         (cfg_q),
  .req_valid_i   (req_valid_i),
  .req_is_data_i (req_is_data_i),
  .req_ready_o   (req_ready_o),
  .cpu_ce_o      (cpu_ce_o),
  .trx_ce_o      (trx_ce_o),
  .bit_stb_o     (bit_stb_o)
);

// File: tb/timing_ctrl_test.sv
`timescale 1ns/1ps
module timing_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xclk = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wd = 8'h00;
  logic       valid = 1'b0;
  logic       is_data = 1'b0;
  logic       req_ready_o, cpu_ce_o, trx_ce_o, bit_stb_o, clk_out_o;

  int checks = 0;
  int fails = 0;
  int bad_rdy = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  timing_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .xclk_i(xclk), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wd), .req_valid_i(valid), .req_is_data_i(is_data),
    .req_ready_o(req_ready_o), .cpu_ce_o(cpu_ce_o), .trx_ce_o(trx_ce_o),
    .bit_stb_o(bit_stb_o), .clk_out_o(clk_out_o)
  );

  // {half, iw[1:0], dw[2:0], is_data}
  localparam logic [6:0] VEC [10] = '{
    {1'b0, 2'd0, 3'd0, 1'b0}, {1'b0, 2'd0, 3'd5, 1'b1},
    {1'b0, 2'd1, 3'd0, 1'b0}, {1'b0, 2'd2, 3'd7, 1'b1},
    {1'b0, 2'd3, 3'd1, 1'b0}, {1'b1, 2'd0, 3'd0, 1'b1},
    {1'b1, 2'd1, 3'd2, 1'b0}, {1'b1, 2'd2, 3'd3, 1'b1},
    {1'b1, 2'd3, 3'd6, 1'b0}, {1'b0, 2'd2, 3'd4, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = d;
    @(negedge clk); cfg_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic access(input logic d, input logic mw, input logic [7:0] md,
                        output int waits);
    int  guard = 0;
    bit  done = 0;
    bit  wrote = 0;
    waits = 0;
    @(negedge clk); valid = 1'b1; is_data = d;
    while (!done && guard < 100) begin
      #2;
      if (req_ready_o && !cpu_ce_o) bad_rdy++;
      if (cpu_ce_o) begin
        if (req_ready_o) done = 1;
        else waits++;
      end
      @(negedge clk);
      guard++;
      cfg_we = 1'b0;
      if (!done && mw && waits == 1 && !wrote) begin
        cfg_we = 1'b1; cfg_wd = md; wrote = 1;
      end
    end
    valid = 1'b0;
    cfg_we = 1'b0;
    if (!done) waits = -1;
  endtask

  task automatic count_en(input int cycles, output int n_ce, output int n_trx,
                          output int n_stb, output int n_pair);
    bit last = 0;
    n_ce = 0; n_trx = 0; n_stb = 0; n_pair = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #2;
      if (cpu_ce_o) n_ce++;
      if (cpu_ce_o && last) n_pair++;
      last = cpu_ce_o;
      if (trx_ce_o) n_trx++;
      if (bit_stb_o) n_stb++;
      if (bit_stb_o && !trx_ce_o) bad_rdy++;
    end
  endtask

  initial begin : main
    int w, a, b, c, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 reset state: full rate, select 00, waits 3 / 7
    count_en(16, a, b, c, e);
    check("R8 cpu_ce count after reset", a, 16);
    check("R8 trx_ce count after reset", b, 16);
    access(1'b0, 1'b0, 8'h00, w); check("R8 instr waits after reset", w, 3);
    access(1'b1, 1'b0, 8'h00, w); check("R8 data waits after reset", w, 7);

    // R1 clock output mirror
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; check("R1 clk_out high phase", int'(clk_out_o), 1);
      @(negedge clk); #1; check("R1 clk_out low phase", int'(clk_out_o), 0);
    end

    // R6 R7 R9 vector table
    for (int i = 0; i < 10; i++) begin
      logic [6:0] v;
      int exp_w;
      v = VEC[i];
      write_cfg({v[3:1], v[5:4], v[6], 2'b00});
      exp_w = v[0] ? int'(v[3:1]) : int'(v[5:4]);
      access(v[0], 1'b0, 8'h00, w);
      if (v[0]) check($sformatf("R7 data waits vec %0d", i), w, exp_w);
      else      check($sformatf("R6 instr waits vec %0d", i), w, exp_w);
      if (exp_w == 0) check($sformatf("R9 zero wait vec %0d", i), w, 0);
    end
    check("R9 ready outside CPU state", bad_rdy, 0);

    // R2 half rate pattern
    write_cfg({3'd0, 2'd0, 1'b1, 2'b00});
    count_en(20, a, b, c, e);
    check("R2 half-rate cpu_ce count", a, 10);
    check("R2 half-rate back-to-back", e, 0);
    write_cfg({3'd0, 2'd0, 1'b0, 2'b00});
    count_en(20, a, b, c, e);
    check("R2 full-rate cpu_ce count", a, 20);

    // R3 R5 dividers and bit strobe
    count_en(128, a, b, c, e);
    check("R3 div1 trx count", b, 128);
    check("R5 div1 bit strobes", c, 16);
    write_cfg({3'd0, 2'd0, 1'b0, 2'b01});
    count_en(128, a, b, c, e);
    check("R3 div2 trx count", b, 64);
    check("R5 div2 bit strobes", c, 8);
    write_cfg({3'd0, 2'd0, 1'b0, 2'b10});
    count_en(64, a, b, c, e);
    check("R3 div4 trx count", b, 16);

    // R4 external clock: 8 rising edges
    write_cfg({3'd0, 2'd0, 1'b0, 2'b11});
    fork
      count_en(72, a, b, c, e);
      for (int k = 0; k < 8; k++) begin
        repeat (4) @(negedge clk); xclk = 1'b1;
        repeat (4) @(negedge clk); xclk = 1'b0;
      end
    join
    check("R4 external edge pulses", b, 8);
    check("R5 strobe only with trx_ce", bad_rdy, 0);

    // R10 mid-access config change
    write_cfg({3'd2, 2'd1, 1'b0, 2'b00});
    access(1'b1, 1'b1, {3'd7, 2'd3, 1'b0, 2'b00}, w);
    check("R10 in-flight access keeps old count", w, 2);
    repeat (2) @(negedge clk);
    access(1'b1, 1'b0, 8'h00, w);
    check("R10 next access uses new count", w, 7);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule